// File: doc/BRIEF.md
# Center-Aligned PWM Counter Channel

This block is a timer counter that drives four pulse-width-modulated outputs from a single shared count. A two-bit mode input picks the counting scheme. The counter can count upward and wrap to zero, count downward and reload, or sweep up to the reload value and back down to zero for symmetric (center-aligned) waveforms. The reload value sets the period. Each channel holds its own compare value, which sets the duty of that channel's output.

The counter advances only on cycles where it is running and the tick-enable input is high, so an external divider sets the count rate. Every wrap of the counter raises a one-cycle update pulse. In center-aligned mode this happens at both ends of the sweep. Each channel has:
- a choice between two complementary PWM modes,
- an output inversion bit,
- an optional compare shadow register, which defers a new compare value to the next update so that no period is cut short.

Top module: `pwmc_timer`

## Requirements
- R1: After reset the count is 0, the count direction reads up (count_down low), update_evt is low, every active compare value is 0, and so with mode and inversion bits low every pwm_out bit is 0 and every cmp_match bit is 1.
- R2: The count changes only on a clock edge where both run and tick_en are high; on every other edge it holds.
- R3: With mode_sel 0 (up), each advance adds one, and an advance from a count at or above reload sets the count to 0 and makes update_evt high for the one cycle in which the count reads 0.
- R4: With mode_sel 1 (down), each advance subtracts one, and an advance from count 0 loads reload and makes update_evt high for the one cycle in which the count reads reload; count_down reads 1.
- R5: With mode_sel 2 (center), starting from 0 the count rises to reload, then falls to 0, then rises again, so one period is 2*reload advances. Each turnaround advance (leaving reload downward, leaving 0 upward after a descent) makes update_evt high for one cycle. count_down is 1 from the turnaround at reload until the turnaround at 0.
- R6: In PWM mode 1 (pwm_mode2 bit 0) with out_invert bit 0, a channel output is 1 exactly while the count is below that channel's active compare value, in every counting mode.
- R7: An active compare value of 0 keeps a mode-1 output at 0 for the whole period, and a value above reload keeps it at 1 for the whole period.
- R8: Setting a channel's pwm_mode2 bit gives the logical inverse of its mode-1 output.
- R9: Setting a channel's out_invert bit inverts that channel's final output, after the mode selection.
- R10: With a channel's cmp_preload bit at 0, a value written through cmp_wr_en/cmp_wr_data (channel i occupies bits i*16 up to i*16+15) becomes the active compare value at the next clock edge.
- R11: With cmp_preload at 1, a written value becomes active only at the edge that raises update_evt. A write on that same edge takes effect at once. Until then the output keeps following the old value.
- R12: cmp_match bit i is 1 exactly while the count equals channel i's active compare value.
- R13: The four channels share the one count but use independent compare values, mode bits and inversion bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Counter enable |
| tick_en | input | 1 | Divided count-rate strobe |
| mode_sel | input | 2 | 0 up, 1 down, 2 center-aligned |
| reload | input | 16 | Period limit |
| cmp_wr_en | input | 4 | Per-channel compare write strobe |
| cmp_wr_data | input | 64 | Compare values, 16 bits per channel |
| cmp_preload | input | 4 | Per-channel shadow enable |
| pwm_mode2 | input | 4 | Per-channel PWM mode 2 select |
| out_invert | input | 4 | Per-channel output inversion |
| pwm_out | output | 4 | PWM outputs |
| cmp_match | output | 4 | Count equals active compare |
| update_evt | output | 1 | One-cycle update pulse |
| count | output | 16 | Current count |
| count_down | output | 1 | Current direction, 1 when falling |

## Verification
The hardest case to reach from the ports is a compare write under preload that lands on the very edge where the counter wraps. That write must take effect at once, whereas a write one cycle earlier must stay hidden for a whole period. The stimulus gets there by counting the ticks it has issued, so it knows when the count equals reload. It then drives the write strobe at that falling edge with tick_en high, and compares the waveform of the next period against both candidate compare values. The sweeps step every compare value from 0 to reload+1 in all three counting modes, so the 0% and 100% ends and both center turnarounds are covered arithmetically.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_CENTER = 2'd2
    } cnt_mode_e;
endpackage

// File: rtl/pwmc_counter.sv
module pwmc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_down_o,
    output logic             upd_o,
    output logic             upd_next_o
);
    import pwmc_pkg::*;

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir_down;
        logic             upd;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    cnt_mode_e  mode;
    logic       adv;

    always_comb begin
        mode = cnt_mode_e'(mode_i);
        adv  = run_i & tick_i;
        st_d = st_q;
        st_d.upd = 1'b0;
        case (mode)
            MODE_DOWN: begin
                st_d.dir_down = 1'b1;
                if (adv) begin
                    if (st_q.cnt == ZERO) begin
                        st_d.cnt = reload_i;
                        st_d.upd = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
            end
            MODE_CENTER: begin
                if (adv) begin
                    if (reload_i == ZERO) begin
                        st_d.cnt      = ZERO;
                        st_d.dir_down = 1'b0;
                        st_d.upd      = 1'b1;
                    end else if (!st_q.dir_down) begin
                        if (st_q.cnt >= reload_i) begin
                            st_d.cnt      = reload_i - ONE;
                            st_d.dir_down = 1'b1;
                            st_d.upd      = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + ONE;
                        end
                    end else begin
                        if (st_q.cnt == ZERO) begin
                            st_d.cnt      = ONE;
                            st_d.dir_down = 1'b0;
                            st_d.upd      = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - ONE;
                        end
                    end
                end
            end
            default: begin
                st_d.dir_down = 1'b0;
                if (adv) begin
                    if (st_q.cnt >= reload_i) begin
                        st_d.cnt = ZERO;
                        st_d.upd = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + ONE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o      = st_q.cnt;
    assign dir_down_o = st_q.dir_down;
    assign upd_o      = st_q.upd;
    assign upd_next_o = st_d.upd;

    assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_i && tick_i) |=> $stable(st_q.cnt));

    assert_up_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && mode_i == 2'd0 && st_q.cnt >= reload_i) |=> (st_q.cnt == ZERO && st_q.upd));

    assert_down_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && mode_i == 2'd1 && st_q.cnt == ZERO) |=> (st_q.cnt == $past(reload_i) && st_q.upd));

    assert_center_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && mode_i == 2'd2 && !st_q.dir_down && reload_i != ZERO && st_q.cnt >= reload_i)
        |=> (st_q.dir_down && st_q.upd));
endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             upd_next_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             preload_i,
    input  logic             mode2_i,
    input  logic             invert_i,
    output logic             out_o,
    output logic             match_o
);
    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      ref_lvl;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.shadow = wr_data_i;
        if (wr_i && !preload_i)  st_d.active = wr_data_i;
        else if (upd_next_i)     st_d.active = st_d.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_lvl = (cnt_i < st_q.active);
    assign out_o   = ref_lvl ^ mode2_i ^ invert_i;
    assign match_o = (cnt_i == st_q.active);

    assert_preload_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_i && !upd_next_i) |=> $stable(st_q.active));

    assert_direct_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !preload_i) |=> (st_q.active == $past(wr_data_i)));
endmodule

// File: rtl/pwmc_timer.sv
module pwmc_timer #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    tick_en,
    input  logic [1:0]              mode_sel,
    input  logic [CNT_W-1:0]        reload,
    input  logic [NUM_CH-1:0]       cmp_wr_en,
    input  logic [NUM_CH*CNT_W-1:0] cmp_wr_data,
    input  logic [NUM_CH-1:0]       cmp_preload,
    input  logic [NUM_CH-1:0]       pwm_mode2,
    input  logic [NUM_CH-1:0]       out_invert,
    output logic [NUM_CH-1:0]       pwm_out,
    output logic [NUM_CH-1:0]       cmp_match,
    output logic                    update_evt,
    output logic [CNT_W-1:0]        count,
    output logic                    count_down
);
    logic [CNT_W-1:0] cnt_w;
    logic             upd_next_w;

    pwmc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .tick_i     (tick_en),
        .mode_i     (mode_sel),
        .reload_i   (reload),
        .cnt_o      (cnt_w),
        .dir_down_o (count_down),
        .upd_o      (update_evt),
        .upd_next_o (upd_next_w)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwmc_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt_i      (cnt_w),
            .upd_next_i (upd_next_w),
            .wr_i       (cmp_wr_en[i]),
            .wr_data_i  (cmp_wr_data[i*CNT_W +: CNT_W]),
            .preload_i  (cmp_preload[i]),
            .mode2_i    (pwm_mode2[i]),
            .invert_i   (out_invert[i]),
            .out_o      (pwm_out[i]),
            .match_o    (cmp_match[i])
        );
    end

    assign count = cnt_w;
endmodule

// File: tb/tb_pwmc_timer.sv
module tb_pwmc_timer;
    localparam int W  = 16;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          run, tick_en;
    logic [1:0]    mode_sel;
    logic [W-1:0]  reload;
    logic [NC-1:0] cmp_wr_en, cmp_preload, pwm_mode2, out_invert;
    logic [NC*W-1:0] cmp_wr_data;
    logic [NC-1:0] pwm_out, cmp_match;
    logic          update_evt, count_down;
    logic [W-1:0]  count;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwmc_timer dut (
        .clk(clk), .rst_n(rst_n), .run(run), .tick_en(tick_en),
        .mode_sel(mode_sel), .reload(reload), .cmp_wr_en(cmp_wr_en),
        .cmp_wr_data(cmp_wr_data), .cmp_preload(cmp_preload),
        .pwm_mode2(pwm_mode2), .out_invert(out_invert), .pwm_out(pwm_out),
        .cmp_match(cmp_match), .update_evt(update_evt), .count(count),
        .count_down(count_down)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run = 0; tick_en = 0; mode_sel = 0; reload = 0;
        cmp_wr_en = 0; cmp_wr_data = 0; cmp_preload = 0; pwm_mode2 = 0; out_invert = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 count", count, 0);
        check("R1 dir", count_down, 0);
        check("R1 update", update_evt, 0);
        check("R1 pwm", pwm_out, 0);
        check("R1 match", cmp_match, 4'hF);
    endtask

    task automatic write_cmp(input int ch, input int val);
        cmp_wr_en = '0;
        cmp_wr_en[ch] = 1'b1;
        cmp_wr_data[ch*W +: W] = W'(val);
    endtask

    function automatic int exp_cnt(input int m, input int r, input int k);
        int p;
        if (m == 0) return k % (r + 1);
        if (m == 1) return (r + 1 - (k % (r + 1))) % (r + 1);
        p = k % (2 * r);
        return (p <= r) ? p : 2 * r - p;
    endfunction

    function automatic int exp_upd(input int m, input int r, input int k);
        if (k == 0) return 0;
        if (m == 0) return (k % (r + 1)) == 0;
        if (m == 1) return ((k - 1) % (r + 1)) == 0;
        return (((k - 1) % (2 * r)) == r) || (((k - 1) % (2 * r)) == 0 && k > 1);
    endfunction

    function automatic int exp_dir(input int m, input int r, input int k);
        int p;
        if (m == 0) return 0;
        if (m == 1) return 1;
        p = k % (2 * r);
        return (p > r) || (p == 0 && k > 0);
    endfunction

    // R5 R6 R7 R8 R9 R12 R13 sweep over compare values and modes
    task automatic sweep(input int m, input int r);
        int c_i [NC];
        for (int c = 0; c <= r + 1; c++) begin
            do_reset();
            mode_sel = 2'(m); reload = W'(r);
            pwm_mode2 = 4'b1010; out_invert = 4'b1100;
            cmp_wr_en = '1;
            for (int i = 0; i < NC; i++) begin
                c_i[i] = (c + i) % (r + 2);
                cmp_wr_data[i*W +: W] = W'(c_i[i]);
            end
            @(negedge clk);
            cmp_wr_en = '0;
            run = 1; tick_en = 1;
            for (int k = 0; k <= 2 * r + 3; k++) begin
                int ec;
                ec = exp_cnt(m, r, k);
                if (m == 0)      check("R3 up count", count, ec);
                else if (m == 1) check("R4 down count", count, ec);
                else             check("R5 center count", count, ec);
                check("R3 R4 R5 update", update_evt, exp_upd(m, r, k));
                check("R4 R5 direction", count_down, exp_dir(m, r, k));
                for (int i = 0; i < NC; i++) begin
                    int lvl;
                    lvl = (ec < c_i[i]) ? 1 : 0;
                    if (c_i[i] == 0)     check("R7 zero duty", (ec < c_i[i]), 0);
                    if (c_i[i] > r)      check("R7 full duty", (ec < c_i[i]), 1);
                    lvl = lvl ^ ((i >> 1) & 1) ^ (i & 1);
                    check("R6 R8 R9 R13 pwm", pwm_out[i], lvl);
                    check("R12 match", cmp_match[i], (ec == c_i[i]));
                end
                @(negedge clk);
            end
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        do_reset();

        // R2: gated advance
        mode_sel = 0; reload = 16'd7; run = 1;
        n = 0;
        for (int k = 0; k < 10; k++) begin
            tick_en = k[0];
            @(negedge clk);
            n += k[0];
            check("R2 tick gating", count, n);
        end
        run = 0; tick_en = 1;
        repeat (3) begin
            @(negedge clk);
            check("R2 run low hold", count, n);
        end

        for (int m = 0; m < 3; m++)
            for (int r = 3; r <= 4; r++)
                sweep(m, r);

        // R10 R11 preload behaviour, up mode, reload 4
        do_reset();
        reload = 16'd4; mode_sel = 0;
        write_cmp(0, 1);
        @(negedge clk);
        cmp_wr_en = 0; cmp_preload[0] = 1; run = 1; tick_en = 1;
        @(negedge clk); @(negedge clk);
        check("R11 setup count", count, 2);
        write_cmp(0, 4);
        @(negedge clk);
        cmp_wr_en = 0;
        check("R11 old value held c3", pwm_out[0], 0);
        @(negedge clk);
        check("R11 old value held c4", pwm_out[0], 0);
        check("R11 no match old", cmp_match[0], 0);
        write_cmp(0, 2);
        cmp_wr_en = 0;
        write_cmp(0, 4);
        cmp_wr_en = 0;
        @(negedge clk);
        check("R11 update count", count, 0);
        check("R11 new value c0", pwm_out[0], 1);
        @(negedge clk);
        check("R11 new value c1", pwm_out[0], 1);
        @(negedge clk); @(negedge clk);
        check("R11 new value c3", pwm_out[0], 1);
        check("R11 count3", count, 3);
        @(negedge clk);
        check("R11 new value c4", pwm_out[0], 0);
        check("R11 match new", cmp_match[0], 1);
        // coincident write with the wrapping edge
        write_cmp(0, 2);
        @(negedge clk);
        cmp_wr_en = 0;
        check("R11 coincident count", count, 0);
        @(negedge clk);
        check("R11 coincident c1", pwm_out[0], 1);
        @(negedge clk);
        check("R11 coincident c2", pwm_out[0], 0);
        check("R11 coincident match", cmp_match[0], 1);

        // R10 direct write, count now 2
        cmp_preload[0] = 0;
        write_cmp(0, 5);
        @(negedge clk);
        cmp_wr_en = 0;
        check("R10 direct count", count, 3);
        check("R10 direct write", pwm_out[0], 1);
        check("R7 above reload", pwm_out[0], 1);
        write_cmp(0, 0);
        @(negedge clk);
        cmp_wr_en = 0;
        check("R10 direct zero", pwm_out[0], 0);
        check("R10 count", count, 4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule